// File: doc/BRIEF.md
# UART Transmitter with Flow Control

This block serialises characters onto an asynchronous line. Software-side logic writes a character into a single-entry hold register. When the transmitter is enabled and the line is not blocked, the character moves into a shift register and goes out as a frame. The frame has one start bit, 7, 8 or 9 data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. The line rests high between frames.

The bit period is 16 × (n + 1) input clock cycles, where n is an 8-bit divisor. An optional active-low clear-to-send input can hold back the start of a frame. It is looked at only when a frame would begin, so a frame that has started always finishes. A one-cycle interrupt pulse marks one of two events, chosen by a select input. The first is the move of a character from the hold register into the shift register. The second is the end of the last stop bit. Writing the hold register while a frame is on the line lets the next frame follow with no idle time.

Top module: `uart_tx_fc`

## Requirements
- R1: After reset, `txd_o` is 1, `buf_empty_o` is 1, `busy_o` is 0 and `irq_o` is 0. Whenever no frame is being sent, `txd_o` is 1.
- R2: A frame is a start bit of 0, then the data bits least significant bit first, then the parity bit if enabled, then the stop bits as 1. The data length comes from `cfg_len_i`: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 gives 9 bits. `cfg_stop2_i` = 1 selects two stop bits, and 0 selects one.
- R3: `cfg_par_i` = 1 selects even parity, so the data bits and the parity bit together hold an even number of ones. `cfg_par_i` = 2 selects odd parity, which makes that count odd. Values 0 and 3 send no parity bit.
- R4: Every bit lasts 16 × (`cfg_div_i` + 1) clock cycles. `busy_o` stays high for exactly the number of frame bits times that period.
- R5: A frame starts only when `tx_en_i` is 1 and the hold register is full. A write (`wr_i` = 1) fills the register and drives `buf_empty_o` to 0. `buf_empty_o` returns to 1 in the cycle the frame starts and `busy_o` rises. While `tx_en_i` is 0, a written character waits.
- R6: When `cts_en_i` is 1, no frame starts while `cts_ni` is 1. A `cts_ni` rise during a frame does not cut that frame short. When `cts_en_i` is 0, `cts_ni` has no effect.
- R7: `irq_o` pulses for one cycle per frame. With `irq_sel_i` = 0, the pulse comes in the cycle `busy_o` rises for that frame. With `irq_sel_i` = 1, it comes in the cycle after the last stop bit ends, which is the cycle `busy_o` falls.
- R8: A character written before the current frame ends starts its own frame at once. Its start bit begins exactly one frame length after the previous start bit.
- R9: Length, parity, stop and divisor settings are captured when a frame starts. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| cfg_div_i | input | 8 | Bit-rate divisor n; bit = 16(n+1) cycles |
| cfg_len_i | input | 2 | Data length: 0=7, 1=8, 2/3=9 bits |
| cfg_par_i | input | 2 | Parity: 0/3 none, 1 even, 2 odd |
| cfg_stop2_i | input | 1 | 1 = two stop bits |
| cts_en_i | input | 1 | 1 = clear-to-send gating active |
| cts_ni | input | 1 | Clear-to-send, active low |
| irq_sel_i | input | 1 | Interrupt event: 0 = load, 1 = shift-out done |
| wr_i | input | 1 | Write strobe for the hold register |
| wr_data_i | input | 9 | Character to send |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | A frame is on the line |
| buf_empty_o | output | 1 | Hold register empty |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench receives random characters through a model receiver that samples each bit at its middle. The random cases cover every length, parity and stop combination and small divisors. This separates errors in bit order, parity sense and stop count. Directed frames of all ones and all zeros show whether parity is computed from the true data bits. A single frame at the largest divisor shows whether the prescaler wraps at the full 8-bit range. Blocked, disabled, back-to-back and mid-frame reconfiguration runs each compare start times and frame contents. Together they show whether gating, the empty flag and the capture of settings act at the frame boundary and nowhere else.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int DATA_W  = 9;
  localparam int DIV_W   = 8;
  localparam int OVS     = 16;
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam logic [1:0] LEN_7    = 2'd0;
  localparam logic [1:0] LEN_8    = 2'd1;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   nbits;
  } frame_t;

  // bit 0 leaves first; unused upper positions stay 1 (stop level)
  function automatic frame_t build_frame(input logic [DATA_W-1:0] d,
                                         input logic [1:0] len,
                                         input logic [1:0] par,
                                         input logic stop2);
    frame_t f;
    int     idx;
    int     dl;
    logic   p;
    f.bits    = '1;
    f.bits[0] = 1'b0;
    idx       = 1;
    p         = 1'b0;
    dl        = (len == LEN_7) ? 7 : (len == LEN_8) ? 8 : 9;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dl) begin
        f.bits[idx] = d[i];
        p           = p ^ d[i];
        idx++;
      end
    end
    if (par == PAR_EVEN) begin
      f.bits[idx] = p;
      idx++;
    end else if (par == PAR_ODD) begin
      f.bits[idx] = ~p;
      idx++;
    end
    idx     = idx + (stop2 ? 2 : 1);
    f.nbits = CNT_W'(idx);
    return f;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int SUB_W = $clog2(OVS);

  logic [DIV_W-1:0] pre_q;
  logic [SUB_W-1:0] sub_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == div_i);
  assign tick_o   = pre_wrap && (sub_q == SUB_W'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      sub_q <= tick_o ? '0 : sub_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      empty_o <= 1'b1;
    end else begin
      if (wr_i) data_o <= wr_data_i;
      // a write in the load cycle refills the register
      if (wr_i)        empty_o <= 1'b0;
      else if (take_i) empty_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FRAME_W = 13,
  parameter int CNT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               tick_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               txd_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;

  assign done_o = busy_o && tick_i && (left_q == '0);
  assign txd_o  = busy_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_o <= 1'b0;
    end else if (load_i) begin
      sh_q   <= frame_i;
      left_q <= nbits_i - 1'b1;
      busy_o <= 1'b1;
    end else if (done_o) begin
      sh_q   <= '1;
      busy_o <= 1'b0;
    end else if (busy_o && tick_i) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [1:0]        cfg_par_i,
  input  logic              cfg_stop2_i,
  input  logic              cts_en_i,
  input  logic              cts_ni,
  input  logic              irq_sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              buf_empty_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] hold_data;
  logic [DIV_W-1:0]  div_q;
  logic              start;
  logic              done;
  logic              tick;
  logic              cts_ok;
  frame_t            frame;

  uart_tx_holdreg #(.DATA_W(DATA_W)) i_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wr_data_i(wr_data_i),
    .take_i   (start),
    .data_o   (hold_data),
    .empty_o  (buf_empty_o)
  );

  assign cts_ok = !cts_en_i || !cts_ni;
  assign start  = tx_en_i && !buf_empty_o && cts_ok && (!busy_o || done);
  assign frame  = build_frame(hold_data, cfg_len_i, cfg_par_i, cfg_stop2_i);

  // divisor captured per frame so a mid-frame change cannot stretch a bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (start) div_q <= cfg_div_i;
  end

  uart_baud_gen #(.DIV_W(DIV_W), .OVS(OVS)) i_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .div_i (div_q),
    .tick_o(tick)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .frame_i(frame.bits),
    .nbits_i(frame.nbits),
    .tick_i (tick),
    .busy_o (busy_o),
    .done_o (done),
    .txd_o  (txd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_sel_i ? done : start;
  end
endmodule

// File: rtl/uart_tx_fc_chk.sv
module uart_tx_fc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic cts_en_i,
  input logic cts_ni,
  input logic irq_sel_i,
  input logic wr_i,
  input logic txd_o,
  input logic busy_o,
  input logic buf_empty_o,
  input logic irq_o
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o); // R1
  AST_FRAME_OPENS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o); // R2
  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !busy_o) |=> !busy_o); // R5
  AST_LOAD_EMPTIES_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !$past(wr_i)) |-> buf_empty_o); // R5
  AST_CTS_BLOCKS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cts_en_i && cts_ni && !busy_o) |=> !busy_o); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R7
  AST_IRQ_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !$past(irq_sel_i)) |-> irq_o); // R7
  AST_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(irq_sel_i)) |-> irq_o); // R7
endmodule

bind uart_tx_fc uart_tx_fc_chk i_chk (.*);

// File: tb/test_uart_tx_fc.sv
`timescale 1ns/1ps
module test_uart_tx_fc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic [7:0] div = 8'd0;
  logic [1:0] len = 2'd1;
  logic [1:0] par = 2'd0;
  logic       stop2 = 1'b0;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       irq_sel = 1'b0;
  logic       wr = 1'b0;
  logic [8:0] wdata = '0;
  logic       txd, busy, bempty, irq;

  int n_run = 0, n_fail = 0, cyc = 0;
  int rise_c = 0, fall_c = 0, irq_c = 0, irq_n = 0;
  logic pb = 1'b0;
  bit   finished = 1'b0;

  uart_tx_fc i_uart_tx_fc (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .cfg_div_i(div),
    .cfg_len_i(len), .cfg_par_i(par), .cfg_stop2_i(stop2),
    .cts_en_i(cts_en), .cts_ni(cts_n), .irq_sel_i(irq_sel),
    .wr_i(wr), .wr_data_i(wdata), .txd_o(txd), .busy_o(busy),
    .buf_empty_o(bempty), .irq_o(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (busy && !pb) rise_c = cyc;
    if (!busy && pb) fall_c = cyc;
    if (irq) begin irq_n++; irq_c = cyc; end
    pb = busy;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void exp_frame(input int d, input int l, input int p,
                                    input bit s2, output logic [12:0] v,
                                    output int n);
    int nd = (l == 0) ? 7 : (l == 1) ? 8 : 9;
    int ones = 0;
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      v[1+i] = 1'((d >> i) & 1);
      ones += (d >> i) & 1;
    end
    n = 1 + nd;
    if (p == 1) begin v[n] = (ones % 2 == 1); n++; end
    else if (p == 2) begin v[n] = (ones % 2 == 0); n++; end
    n += s2 ? 2 : 1;
  endfunction

  task automatic write_data(input int d);
    @(negedge clk);
    wr = 1'b1;
    wdata = 9'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rx_frame(input logic [12:0] ev, input int n, input int bc,
                          input string req, output int c0);
    logic [12:0] got = '1;
    logic [12:0] mask;
    bit found = 0;
    c0 = 0;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk); #1;
      if (!txd) begin found = 1; break; end
    end
    chk(found, req, "start bit seen", int'(found), 1);
    if (found) begin
      c0 = cyc;
      repeat (bc / 2) @(posedge clk);
      #1 got[0] = txd;
      for (int i = 1; i < n; i++) begin
        repeat (bc) @(posedge clk);
        #1 got[i] = txd;
      end
      mask = 13'((1 << n) - 1);
      chk((got & mask) == (ev & mask), req, "frame bits",
          int'(got & mask), int'(ev & mask));
    end
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 70000; k++) begin
      @(posedge clk); #1;
      if (!busy) break;
    end
  endtask

  // single frame with full checks on contents, length and interrupt
  task automatic run_frame(input int d, input string req);
    logic [12:0] ev;
    int n, bc, c0, irq0;
    bit sel;
    exp_frame(d, int'(len), int'(par), stop2, ev, n);
    bc = 16 * (int'(div) + 1);
    sel = irq_sel;
    irq0 = irq_n;
    write_data(d);
    rx_frame(ev, n, bc, req, c0);
    wait_idle();
    #0;
    chk(fall_c - rise_c == n * bc, "R4", "busy length", fall_c - rise_c, n * bc);
    chk(irq_n - irq0 == 1, "R7", "irq pulses", irq_n - irq0, 1);
    chk(irq_c == (sel ? fall_c : rise_c), "R7", "irq cycle", irq_c,
        sel ? fall_c : rise_c);
  endtask

  initial begin
    int c0a, c0b, n1, n2;
    logic [12:0] e1, e2;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    chk(bempty == 1'b1, "R1", "buf_empty in reset", int'(bempty), 1);
    chk(irq == 1'b0 && busy == 1'b0, "R1", "irq/busy in reset", int'({irq, busy}), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R1", "idle line", int'(txd), 1);

    // R2 R3 R4 R7 random formats
    for (int t = 0; t < 24; t++) begin
      @(negedge clk);
      len = 2'($urandom % 4);
      par = 2'($urandom % 4);
      stop2 = 1'($urandom % 2);
      div = 8'($urandom % 3);
      irq_sel = 1'($urandom % 2);
      run_frame(int'($urandom % 512), "R2/R3");
    end

    // R3 parity corners
    @(negedge clk); len = 2'd2; par = 2'd1; stop2 = 1'b1; div = 8'd0;
    run_frame(9'h1FF, "R3_even_ones");
    @(negedge clk); par = 2'd2;
    run_frame(9'h000, "R3_odd_zeros");
    @(negedge clk); len = 2'd0; par = 2'd2;
    run_frame(9'h17F, "R3_odd_7bit");

    // R4 largest divisor
    @(negedge clk); len = 2'd0; par = 2'd0; stop2 = 1'b0; div = 8'hFF; irq_sel = 1'b1;
    run_frame(9'h055, "R4_maxdiv");
    @(negedge clk); div = 8'd1; irq_sel = 1'b0; len = 2'd1;

    // R5 enable gating
    tx_en = 1'b0;
    write_data(9'h0A5);
    repeat (100) @(posedge clk);
    #1 chk(!busy && txd && !bempty, "R5", "held while disabled",
           int'({busy, txd, bempty}), 3'b010);
    @(negedge clk) tx_en = 1'b1;
    exp_frame(9'h0A5, 1, 0, 0, e1, n1);
    rx_frame(e1, n1, 32, "R5_release", c0a);
    wait_idle();

    // R6 clear-to-send blocking, release, mid-frame, ignored
    @(negedge clk); cts_en = 1'b1; cts_n = 1'b1;
    write_data(9'h03C);
    repeat (150) @(posedge clk);
    #1 chk(!busy && txd && !bempty, "R6", "blocked by cts",
           int'({busy, txd, bempty}), 3'b010);
    @(negedge clk) cts_n = 1'b0;
    exp_frame(9'h03C, 1, 0, 0, e1, n1);
    rx_frame(e1, n1, 32, "R6_release", c0a);
    wait_idle();
    fork
      run_frame(9'h0C3, "R6_midframe");
      begin repeat (60) @(negedge clk); cts_n = 1'b1; end
    join
    @(negedge clk); cts_en = 1'b0;
    run_frame(9'h111, "R6_ignored");

    // R8 back-to-back
    exp_frame(9'h0F0, 1, 0, 0, e1, n1);
    exp_frame(9'h00F, 1, 0, 0, e2, n2);
    write_data(9'h0F0);
    fork
      begin
        rx_frame(e1, n1, 32, "R8_first", c0a);
        rx_frame(e2, n2, 32, "R8_second", c0b);
      end
      begin
        for (int k = 0; k < 100; k++) begin
          @(posedge clk); #1;
          if (bempty) break;
        end
        write_data(9'h00F);
      end
    join
    chk(c0b - c0a == n1 * 32, "R8", "gap-free start", c0b - c0a, n1 * 32);
    wait_idle();

    // R9 settings captured at start
    @(negedge clk); len = 2'd2; par = 2'd1; stop2 = 1'b1; div = 8'd1;
    fork
      run_frame(9'h1A6, "R9_latched");
      begin
        repeat (50) @(negedge clk);
        len = 2'd0; par = 2'd0; stop2 = 1'b0; div = 8'd3;
      end
    join

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule